// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block translates a virtual page number into a physical page number by fetching one entry from a flat page table that lives in physical memory. A client presents a page number together with the kind of access it intends: a data load, a data store or an instruction fetch. The walker computes where the entry sits and issues a single word read on a simple request/response memory port. It then decodes the returned word and reports one of three outcomes. The outcome is either a successful translation carrying the physical page number, a page fault for an entry that is not resident, or a protection violation for an access the entry forbids.

The walker serves one translation at a time. It latches the table base and the page number when it accepts a request, so the base register may be reprogrammed while a walk is in flight. The answer is held on the response port until the client takes it. Only after that handshake does the walker accept new work.

Top module: `pt_walker`

## Requirements
- R1: The entry address sent to memory equals the table base plus four times the page number, modulo 2^PA_W. Both values are taken at the cycle the request is accepted, and later changes on the base input have no effect on that walk.
- R2: `req_ready_o` is high only when no walk is in progress. `busy_o` rises in the cycle after acceptance and stays high until the response handshake completes, and only then does the walker become ready again.
- R3: Each accepted request produces exactly one memory read. `mem_req_valid_o` stays high with an unchanged address until `mem_req_ready_i` is seen, and drops in the cycle after that handshake.
- R4: The entry word is laid out as follows: bit 31 is the resident flag, bits 30:29 are the rights code, and bits PPN_W-1:0 are the physical page number. Bits between them are ignored. A clear resident flag gives a page fault.
- R5: The rights code is 00 for no access, 01 for read-only, 10 for read/write and 11 for execute. The access code is 00 for load, 01 for store, 10 for fetch and 11 for reserved. A load is allowed under 01 or 10, a store only under 10 and a fetch only under 11. A reserved access is never allowed. A resident entry that forbids the access gives a protection violation.
- R6: A page fault takes precedence over a protection violation: a non-resident entry reports a fault whatever its rights code.
- R7: While `rsp_valid_o` is high, exactly one of `rsp_ok_o`, `rsp_fault_o` and `rsp_prot_o` is set. The response outputs stay stable until `rsp_ready_i`. `rsp_ppn_o` carries the entry's page number on success and zero otherwise. All response flags are zero when `rsp_valid_o` is low.
- R8: During and after reset the walker is ready and not busy, and it drives no memory request and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptbr_i | input | PA_W | Physical base address of the page table |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vpn_i | input | VPN_W | Virtual page number to translate |
| req_acc_i | input | 2 | Access kind (R5 encoding) |
| busy_o | output | 1 | Walk in progress |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | PA_W | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_data_i | input | 32 | Entry word |
| rsp_valid_o | output | 1 | Translation result present |
| rsp_ready_i | input | 1 | Client takes the result |
| rsp_ppn_o | output | PPN_W | Physical page number |
| rsp_ok_o | output | 1 | Translation succeeded |
| rsp_fault_o | output | 1 | Entry not resident |
| rsp_prot_o | output | 1 | Access not permitted |

## Verification
A wrong controller state shows up within a cycle or two as a visible port error. It can appear as a second or missing memory read, a read to a shifted address, a ready signal raised during a walk, or a response that drops before the client takes it. A corrupted latched access kind or a faulty decode first shows up only at the response for that walk, where the outcome flag or the page number is wrong. The bench therefore checks the address of every read and the outcome of every response. It also checks that the outputs hold steady through memory and client stalls of several lengths.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_W     = 32;
  localparam int PTE_BYTES = PTE_W / 8;
  localparam int PTE_V_BIT = 31;
  localparam int PTE_R_HI  = 30;
  localparam int PTE_R_LO  = 29;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    RGT_NONE = 2'b00,
    RGT_RO   = 2'b01,
    RGT_RW   = 2'b10,
    RGT_EXEC = 2'b11
  } rights_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_RESP
  } walk_state_e;

  typedef struct packed {
    logic ok;
    logic fault;
    logic prot;
  } outcome_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W      = 32,
  parameter int VPN_W     = 20,
  parameter int PTE_BYTES = 4
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [PA_W-1:0]  entry_addr_o
);
  localparam int SHIFT    = $clog2(PTE_BYTES);
  localparam int SCALED_W = VPN_W + SHIFT;

  logic [SCALED_W-1:0] scaled;
  logic [PA_W-1:0]     offs;

  assign scaled = SCALED_W'(vpn_i) << SHIFT;

  generate
    if (SCALED_W > PA_W) begin : g_trunc
      logic unused_hi;
      assign unused_hi = ^scaled[SCALED_W-1:PA_W];
      assign offs = scaled[PA_W-1:0];
    end else if (SCALED_W == PA_W) begin : g_exact
      assign offs = scaled;
    end else begin : g_ext
      assign offs = {{(PA_W-SCALED_W){1'b0}}, scaled};
    end
  endgenerate

  // modulo 2^PA_W wrap is intended
  assign entry_addr_o = base_i + offs;
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int PPN_W = 20
) (
  input  logic [PTE_W-1:0] pte_i,
  input  acc_e             acc_i,
  output logic [PPN_W-1:0] ppn_o,
  output outcome_t         res_o
);
  logic    resident;
  logic    allowed;
  rights_e rights;

  assign resident = pte_i[PTE_V_BIT];
  assign rights   = rights_e'(pte_i[PTE_R_HI:PTE_R_LO]);
  assign ppn_o    = pte_i[PPN_W-1:0];

  generate
    if (PPN_W < PTE_R_LO) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^pte_i[PTE_R_LO-1:PPN_W];
    end
  endgenerate

  always_comb begin
    unique case (acc_i)
      ACC_LOAD:  allowed = (rights == RGT_RO) || (rights == RGT_RW);
      ACC_STORE: allowed = (rights == RGT_RW);
      ACC_FETCH: allowed = (rights == RGT_EXEC);
      default:   allowed = 1'b0;
    endcase
  end

  // fault wins over rights check
  always_comb begin
    res_o.fault = ~resident;
    res_o.prot  = resident & ~allowed;
    res_o.ok    = resident & allowed;
  end

  always_comb begin
    p_fault_prio_r6: assert (resident || (res_o.fault && !res_o.prot && !res_o.ok));
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_acc_i,
  input  logic [PA_W-1:0]  entry_addr_i,
  output acc_e             acc_o,
  output logic             busy_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PPN_W-1:0] dec_ppn_i,
  input  outcome_t         dec_res_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PPN_W-1:0] rsp_ppn_o,
  output logic             rsp_ok_o,
  output logic             rsp_fault_o,
  output logic             rsp_prot_o
);
  walk_state_e      state_q, state_d;
  logic [PA_W-1:0]  addr_q;
  acc_e             acc_q;
  logic [PPN_W-1:0] ppn_q;
  outcome_t         res_q;
  logic             accept;
  logic             capture;

  assign accept  = (state_q == ST_IDLE) && req_valid_i;
  assign capture = (state_q == ST_WAIT) && mem_rsp_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i)     state_d = ST_READ;
      ST_READ: if (mem_req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid_i) state_d = ST_RESP;
      ST_RESP: if (rsp_ready_i)     state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      acc_q   <= ACC_LOAD;
      ppn_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= entry_addr_i;
        acc_q  <= acc_e'(req_acc_i);
      end
      if (capture) begin
        ppn_q <= dec_res_i.ok ? dec_ppn_i : '0;
        res_q <= dec_res_i;
      end
    end
  end

  assign acc_o           = acc_q;
  assign req_ready_o     = (state_q == ST_IDLE);
  assign busy_o          = (state_q != ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_READ);
  assign mem_req_addr_o  = addr_q;
  assign rsp_valid_o     = (state_q == ST_RESP);
  assign rsp_ppn_o       = rsp_valid_o ? ppn_q : '0;
  assign rsp_ok_o        = rsp_valid_o & res_q.ok;
  assign rsp_fault_o     = rsp_valid_o & res_q.fault;
  assign rsp_prot_o      = rsp_valid_o & res_q.prot;

  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (busy_o && !req_ready_o));

  p_ready_after_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ready_i) |=> (req_ready_o && !busy_o));

  p_memreq_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  p_memreq_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

  p_one_outcome_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones({rsp_ok_o, rsp_fault_o, rsp_prot_o}) == 1));

  p_rsp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_ppn_o) && $stable(rsp_ok_o)
                                       && $stable(rsp_fault_o) && $stable(rsp_prot_o)));

  p_quiet_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_ok_o || rsp_fault_o || rsp_prot_o));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter  int VA_W       = 32,
  parameter  int PA_W       = 32,
  parameter  int PAGE_OFF_W = 12,
  localparam int VPN_W      = VA_W - PAGE_OFF_W,
  localparam int PPN_W      = PA_W - PAGE_OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PA_W-1:0]  ptbr_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [1:0]       req_acc_i,
  output logic             busy_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [31:0]      mem_rsp_data_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PPN_W-1:0] rsp_ppn_o,
  output logic             rsp_ok_o,
  output logic             rsp_fault_o,
  output logic             rsp_prot_o
);
  logic [PA_W-1:0]  entry_addr;
  acc_e             acc_q;
  logic [PPN_W-1:0] dec_ppn;
  outcome_t         dec_res;

  ptw_addr_gen #(
    .PA_W      (PA_W),
    .VPN_W     (VPN_W),
    .PTE_BYTES (PTE_BYTES)
  ) u_addr_gen (
    .base_i       (ptbr_i),
    .vpn_i        (req_vpn_i),
    .entry_addr_o (entry_addr)
  );

  ptw_pte_decode #(
    .PPN_W (PPN_W)
  ) u_decode (
    .pte_i (mem_rsp_data_i),
    .acc_i (acc_q),
    .ppn_o (dec_ppn),
    .res_o (dec_res)
  );

  ptw_ctrl #(
    .PA_W  (PA_W),
    .PPN_W (PPN_W)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_acc_i       (req_acc_i),
    .entry_addr_i    (entry_addr),
    .acc_o           (acc_q),
    .busy_o          (busy_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .dec_ppn_i       (dec_ppn),
    .dec_res_i       (dec_res),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_ppn_o       (rsp_ppn_o),
    .rsp_ok_o        (rsp_ok_o),
    .rsp_fault_o     (rsp_fault_o),
    .rsp_prot_o      (rsp_prot_o)
  );

  p_reset_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (req_ready_o && !busy_o && !mem_req_valid_o && !rsp_valid_o));
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  localparam int PA_W  = 32;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] pte;
    int          mstall;
    int          mlat;
  } mem_item_t;

  typedef struct {
    logic [PPN_W-1:0] ppn;
    logic [2:0]       flags;  // {ok, fault, prot}
    int               rstall;
    string            tag;
  } rsp_item_t;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [PA_W-1:0]  ptbr_i = '0;
  logic             req_valid_i = 1'b0;
  logic             req_ready_o;
  logic [VPN_W-1:0] req_vpn_i = '0;
  logic [1:0]       req_acc_i = '0;
  logic             busy_o;
  logic             mem_req_valid_o;
  logic             mem_req_ready_i = 1'b0;
  logic [PA_W-1:0]  mem_req_addr_o;
  logic             mem_rsp_valid_i = 1'b0;
  logic [31:0]      mem_rsp_data_i = '0;
  logic             rsp_valid_o;
  logic             rsp_ready_i = 1'b0;
  logic [PPN_W-1:0] rsp_ppn_o;
  logic             rsp_ok_o, rsp_fault_o, rsp_prot_o;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  mem_item_t mq[$];
  rsp_item_t rq[$];

  always #2.5 clk = ~clk;

  pt_walker u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .ptbr_i (ptbr_i),
    .req_valid_i (req_valid_i), .req_ready_o (req_ready_o),
    .req_vpn_i (req_vpn_i), .req_acc_i (req_acc_i), .busy_o (busy_o),
    .mem_req_valid_o (mem_req_valid_o), .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o (mem_req_addr_o), .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i (mem_rsp_data_i), .rsp_valid_o (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i), .rsp_ppn_o (rsp_ppn_o), .rsp_ok_o (rsp_ok_o),
    .rsp_fault_o (rsp_fault_o), .rsp_prot_o (rsp_prot_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected outcome from the R4/R5/R6 rules
  function automatic logic [2:0] outcome(input logic [31:0] pte, input logic [1:0] acc);
    logic [1:0] r;
    logic       allow;
    r = pte[30:29];
    if (!pte[31]) return 3'b010;
    allow = (acc == 2'b00 && (r == 2'b01 || r == 2'b10)) ||
            (acc == 2'b01 && r == 2'b10) ||
            (acc == 2'b10 && r == 2'b11);
    return allow ? 3'b100 : 3'b001;
  endfunction

  function automatic logic [31:0] mk_pte(input bit v, input logic [1:0] r, input logic [19:0] ppn);
    return {v, r, 9'h1A5, ppn};
  endfunction

  task automatic translate(input logic [31:0] base, input logic [19:0] vpn, input logic [1:0] acc,
                           input logic [31:0] pte, input int mstall, input int mlat,
                           input int rstall, input string tag);
    mem_item_t m;
    rsp_item_t r;
    m.addr = base + {10'd0, vpn, 2'b00};
    m.pte = pte; m.mstall = mstall; m.mlat = mlat;
    r.flags = outcome(pte, acc);
    r.ppn = r.flags[2] ? pte[19:0] : '0;
    r.rstall = rstall; r.tag = tag;
    mq.push_back(m);
    rq.push_back(r);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    ptbr_i = base; req_vpn_i = vpn; req_acc_i = acc; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    ptbr_i = ~base;              // R1: must not affect the walk
    req_vpn_i = ~vpn;
    req_acc_i = ~acc;
  endtask

  // memory model
  initial begin
    mem_item_t m;
    forever begin
      @(negedge clk);
      if (mem_req_valid_o) begin
        if (mq.size() == 0) begin
          chk(1'b0, "R3", "unexpected extra read", mem_req_addr_o, 32'h0);
          mem_req_ready_i = 1'b1;
          @(negedge clk);
          mem_req_ready_i = 1'b0;
        end else begin
          m = mq.pop_front();
          chk(mem_req_addr_o == m.addr, "R1", "entry address", mem_req_addr_o, m.addr);
          for (int i = 0; i < m.mstall; i++) begin
            @(negedge clk);
            chk(mem_req_valid_o && mem_req_addr_o == m.addr, "R3", "held read address",
                mem_req_addr_o, m.addr);
          end
          mem_req_ready_i = 1'b1;
          @(negedge clk);
          mem_req_ready_i = 1'b0;
          chk(!mem_req_valid_o, "R3", "read dropped after handshake", 32'(mem_req_valid_o), 32'h0);
          repeat (m.mlat) @(negedge clk);
          mem_rsp_data_i = m.pte;
          mem_rsp_valid_i = 1'b1;
          @(negedge clk);
          mem_rsp_valid_i = 1'b0;
          mem_rsp_data_i = 32'hDEAD_BEEF;
        end
      end
    end
  end

  // response monitor / scoreboard
  initial begin
    rsp_item_t cur;
    bit have = 1'b0;
    int stall = 0;
    logic [PPN_W+2:0] first;
    forever begin
      @(negedge clk);
      if (rsp_valid_o && !rsp_ready_i) begin
        if (!have) begin
          if (rq.size() == 0) begin
            chk(1'b0, "R7", "response with no request", 32'(rsp_ppn_o), 32'h0);
            rsp_ready_i = 1'b1;
          end else begin
            cur = rq.pop_front();
            have = 1'b1;
            stall = cur.rstall;
            first = {rsp_ppn_o, rsp_ok_o, rsp_fault_o, rsp_prot_o};
            chk(busy_o && !req_ready_o, "R2", "busy during walk",
                32'({busy_o, req_ready_o}), 32'b10);
          end
        end else begin
          chk({rsp_ppn_o, rsp_ok_o, rsp_fault_o, rsp_prot_o} == first, "R7",
              "response stable under stall", 32'({rsp_ppn_o, rsp_ok_o, rsp_fault_o, rsp_prot_o}),
              32'(first));
        end
        if (have) begin
          if (stall > 0) stall--;
          else begin
            chk({rsp_ok_o, rsp_fault_o, rsp_prot_o} == cur.flags, cur.tag, "outcome flags",
                32'({rsp_ok_o, rsp_fault_o, rsp_prot_o}), 32'(cur.flags));
            chk(rsp_ppn_o == cur.ppn, "R7", "page number", 32'(rsp_ppn_o), 32'(cur.ppn));
            rsp_ready_i = 1'b1;
            have = 1'b0;
          end
        end
      end else begin
        if (rsp_ready_i && !rsp_valid_o)
          chk(!rsp_ok_o && !rsp_fault_o && !rsp_prot_o, "R7", "flags quiet when idle",
              32'({rsp_ok_o, rsp_fault_o, rsp_prot_o}), 32'h0);
        rsp_ready_i = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(req_ready_o && !busy_o && !mem_req_valid_o && !rsp_valid_o, "R8", "state in reset",
        32'({req_ready_o, busy_o, mem_req_valid_o, rsp_valid_o}), 32'b1000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o && !busy_o && !mem_req_valid_o && !rsp_valid_o, "R8", "state after reset",
        32'({req_ready_o, busy_o, mem_req_valid_o, rsp_valid_o}), 32'b1000);

    translate(32'h0010_0000, 20'h00001, 2'b00, mk_pte(1, 2'b01, 20'hABCDE), 0, 0, 0, "R5");
    translate(32'h0010_0000, 20'h00042, 2'b01, mk_pte(1, 2'b10, 20'h12345), 2, 3, 2, "R5");
    translate(32'h0020_0000, 20'h00100, 2'b01, mk_pte(1, 2'b01, 20'h55555), 1, 0, 1, "R5");
    translate(32'h0020_0000, 20'h00101, 2'b10, mk_pte(1, 2'b11, 20'h0F0F0), 0, 1, 0, "R5");
    translate(32'h0020_0000, 20'h00102, 2'b10, mk_pte(1, 2'b10, 20'h0F0F1), 0, 0, 3, "R5");
    translate(32'h0030_0000, 20'h00200, 2'b00, mk_pte(1, 2'b11, 20'h11111), 0, 0, 0, "R5");
    translate(32'h0030_0000, 20'h00201, 2'b00, mk_pte(1, 2'b00, 20'h22222), 0, 2, 0, "R5");
    translate(32'h0030_0000, 20'h00202, 2'b00, mk_pte(1, 2'b10, 20'h33333), 3, 0, 0, "R5");
    translate(32'h0030_0000, 20'h00203, 2'b11, mk_pte(1, 2'b10, 20'h44444), 0, 0, 0, "R5");
    translate(32'h0030_0000, 20'h00204, 2'b01, mk_pte(0, 2'b10, 20'hFFFFF), 0, 0, 1, "R4");
    translate(32'h0030_0000, 20'h00205, 2'b10, mk_pte(0, 2'b00, 20'h77777), 1, 1, 0, "R6");
    translate(32'h0030_0000, 20'h00206, 2'b01, mk_pte(0, 2'b01, 20'h88888), 0, 0, 0, "R6");
    translate(32'hFFFF_FFF0, 20'hFFFFF, 2'b00, mk_pte(1, 2'b01, 20'hFFFFF), 0, 0, 0, "R1");
    translate(32'h0000_0000, 20'hFFFFF, 2'b10, mk_pte(1, 2'b11, 20'h00000), 0, 0, 0, "R4");
    translate(32'h0000_1004, 20'h00000, 2'b00, mk_pte(1, 2'b10, 20'h9ABCD), 4, 4, 4, "R5");

    while (rq.size() != 0 || busy_o) @(negedge clk);
    @(negedge clk);
    chk(req_ready_o && !busy_o && !mem_req_valid_o, "R2", "idle after last response",
        32'({req_ready_o, busy_o, mem_req_valid_o}), 32'b100);
    chk(mq.size() == 0, "R3", "all reads issued", 32'(mq.size()), 32'h0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule